// File: doc/BRIEF.md
# Complex Interpolating Trace Modulator

This block turns a decimated complex baseband echo trace back into its full-rate form. Compressed samples arrive one at a time on a valid/ready stream as separate in-phase and quadrature words. Each compressed sample is expanded into a group of `UPS` output slots, with zeros placed between the samples. The zero-stuffed sequence is passed through a short fixed low-pass FIR filter. Every filtered sample is then rotated by a phase that advances by one eighth of a turn per output sample. The result leaves on a second valid/ready stream, one complex sample per cycle, and a start-of-trace flag marks the first sample of each trace.

The filter has at most `UPS` taps, so each output slot depends on only one compressed sample. Slot `r` of compressed sample `x` equals `h[r]·x`, and any slot at or above the tap count is zero. This polyphase form gives the same bits as the direct convolution of the zero-stuffed stream, but it needs no delay line and performs one multiply per part per output. The rotation takes its cosine and sine from an eight-entry set built from 0, ±1 and ±√2/2, so no oscillator is needed. A trace is `TRACE_IN` compressed samples long. The phase restarts, and the filter history is empty, at the start of every trace.

Top module: `trace_interp_mod`

## Requirements
- R1: During and after a synchronous active-low reset, with no input offered, `m_valid` is 0 and `s_ready` is 1.
- R2: Each accepted input sample yields exactly `UPS` output samples. No other outputs appear. `m_sot` is 1 on the first output of every trace of `TRACE_IN` inputs and 0 on all other outputs.
- R3: Before rotation, output slot r (0-based within an input sample's group) carries `h[r]·x` rounded and saturated as in R6. Tap `h[r]` is the Q1.15 value in `COEFS[r*CW +: CW]`. Slots with r ≥ `NTAP` carry zero. Where the rotation is ±1 (phase index 0 or 4), this value, or its negation, is visible at the output.
- R4: For output m within a trace, counted from 0, the phase index is p = (m+1) mod 8 and the angle is p·45°. The rotation constants are C = cos and S = sin, scaled by 2^15, taken from {0, ±32768, ±23170}. The outputs are `m_i = rnd(f_i·C − f_q·S)` and `m_q = rnd(f_i·S + f_q·C)`.
- R5: The phase index restarts at 1 on the first output of every trace, even when the trace length is not a multiple of 8. No value from one trace reaches the next.
- R6: Each rounding step adds 2^14 and shifts right arithmetically by 15 (round half up). The result is then clamped to [−32768, 32767].
- R7: While the output is stalled, the input is back-pressured. Every accepted sample still produces its outputs in order, and none is dropped or duplicated.
- R8: While `m_valid` is 1 and `m_ready` is 0, `m_valid`, `m_i`, `m_q` and `m_sot` hold their values into the next cycle.
- R9: When input is always offered and `m_ready` is always 1, `m_valid` stays high without gaps from the first output to the last. The next input is accepted in the same cycle as the last slot of the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Compressed sample offered |
| s_ready | output | 1 | Block can take a compressed sample |
| s_i | input | DW | Compressed sample, in-phase part (signed) |
| s_q | input | DW | Compressed sample, quadrature part (signed) |
| m_valid | output | 1 | Full-rate sample present |
| m_ready | input | 1 | Downstream takes the sample |
| m_i | output | DW | Full-rate sample, in-phase part (signed) |
| m_q | output | DW | Full-rate sample, quadrature part (signed) |
| m_sot | output | 1 | First sample of a trace |

## Verification
The bench builds the block with `UPS`=6, `NTAP`=5 and `TRACE_IN`=3. One of the five taps is negative, and one is exactly one half, which tests rounding of ties. With these values a trace has 18 outputs. That is not a multiple of 8, so the phase restart at the second trace differs from a free-running phase. Each input group also contains one slot above the tap count, which must be zero. The short traces let the bench run several back-to-back traces under three output-ready patterns, with extreme inputs that drive the 45° rotation into saturation.

// File: rtl/tim_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the trace interpolator.
// The rotation constants are held in 18-bit signed form so that exactly
// +1.0 (32768 at 15 fractional bits) is representable.
package tim_pkg;
    localparam int ROT_FRAC = 15;
    localparam int ROT_W    = ROT_FRAC + 3;

    typedef logic [2:0] phase_t;

    localparam logic signed [ROT_W-1:0] ROT_ONE  = 18'sd32768;
    localparam logic signed [ROT_W-1:0] ROT_DIAG = 18'sd23170;

    // cosine of p*45 degrees, scaled by 2^ROT_FRAC
    function automatic logic signed [ROT_W-1:0] rot_cos(input phase_t p);
        case (p)
            3'd0:    return ROT_ONE;
            3'd1:    return ROT_DIAG;
            3'd2:    return '0;
            3'd3:    return -ROT_DIAG;
            3'd4:    return -ROT_ONE;
            3'd5:    return -ROT_DIAG;
            3'd6:    return '0;
            default: return ROT_DIAG;
        endcase
    endfunction

    // sine of p*45 degrees, scaled by 2^ROT_FRAC
    function automatic logic signed [ROT_W-1:0] rot_sin(input phase_t p);
        case (p)
            3'd0:    return '0;
            3'd1:    return ROT_DIAG;
            3'd2:    return ROT_ONE;
            3'd3:    return ROT_DIAG;
            3'd4:    return '0;
            3'd5:    return -ROT_DIAG;
            3'd6:    return -ROT_ONE;
            default: return -ROT_DIAG;
        endcase
    endfunction
endpackage

// File: rtl/tim_tap_slot.sv
`timescale 1ns/1ps
// Polyphase filter slot: scales one compressed complex sample by the tap
// that belongs to the current output slot.
// Assumes NTAP <= UPS, so every output of the zero-stuffed convolution
// depends on a single compressed sample; slots at or above NTAP are zero.
// Rounding is half up, result saturated to DW bits. Purely combinational.
module tim_tap_slot #(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int UPS  = 8,
    parameter int NTAP = 7,
    parameter int SW   = $clog2(UPS),
    parameter logic [NTAP*CW-1:0] COEFS = '0
) (
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] x_q,
    input  logic [SW-1:0]        slot,
    output logic signed [DW-1:0] f_i,
    output logic signed [DW-1:0] f_q
);
    localparam int FR  = CW - 1;
    localparam int PRW = DW + CW + 1;
    localparam logic signed [PRW-1:0] HALF   = PRW'(64'sd1 <<< (FR - 1));
    localparam logic signed [PRW-1:0] SAT_HI = PRW'((64'sd1 <<< (DW - 1)) - 64'sd1);
    localparam logic signed [PRW-1:0] SAT_LO = -SAT_HI - PRW'(1);

    logic signed [CW-1:0] tap_tbl [UPS];

    // one table entry per slot: a live tap or a structural zero
    for (genvar g = 0; g < UPS; g++) begin : g_tap
        if (g < NTAP) begin : g_live
            assign tap_tbl[g] = $signed(COEFS[g*CW +: CW]);
        end else begin : g_gap
            assign tap_tbl[g] = '0;
        end
    end

    // multiply, round half up, clamp
    function automatic logic signed [DW-1:0] scale(input logic signed [DW-1:0] x,
                                                   input logic signed [CW-1:0] h);
        logic signed [PRW-1:0] acc;
        acc = PRW'(x) * PRW'(h);
        acc = (acc + HALF) >>> FR;
        if (acc > SAT_HI)      return DW'(SAT_HI);
        else if (acc < SAT_LO) return DW'(SAT_LO);
        else                   return DW'(acc);
    endfunction

    logic signed [CW-1:0] cur_tap;

    // select the tap of the current slot and apply it to both parts
    always_comb begin
        cur_tap = tap_tbl[slot];
        f_i     = scale(x_i, cur_tap);
        f_q     = scale(x_q, cur_tap);
    end
endmodule

// File: rtl/tim_rotor.sv
`timescale 1ns/1ps
// Complex rotation by p*45 degrees using fixed constants from tim_pkg.
// Full complex multiply, round half up, saturate to DW bits.
// Purely combinational; assumes the caller holds inputs stable.
module tim_rotor
    import tim_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] f_i,
    input  logic signed [DW-1:0] f_q,
    input  phase_t               ph,
    output logic signed [DW-1:0] y_i,
    output logic signed [DW-1:0] y_q
);
    localparam int AW = DW + ROT_W + 2;
    localparam logic signed [AW-1:0] HALF   = AW'(64'sd1 <<< (ROT_FRAC - 1));
    localparam logic signed [AW-1:0] SAT_HI = AW'((64'sd1 <<< (DW - 1)) - 64'sd1);
    localparam logic signed [AW-1:0] SAT_LO = -SAT_HI - AW'(1);

    // round half up and clamp a wide sum back to DW bits
    function automatic logic signed [DW-1:0] fit(input logic signed [AW-1:0] v);
        logic signed [AW-1:0] t;
        t = (v + HALF) >>> ROT_FRAC;
        if (t > SAT_HI)      return DW'(SAT_HI);
        else if (t < SAT_LO) return DW'(SAT_LO);
        else                 return DW'(t);
    endfunction

    logic signed [ROT_W-1:0] c_k, s_k;
    logic signed [AW-1:0]    acc_i, acc_q;

    // complex product (f_i + j f_q)(c + j s)
    always_comb begin
        c_k   = rot_cos(ph);
        s_k   = rot_sin(ph);
        acc_i = AW'(f_i) * AW'(c_k) - AW'(f_q) * AW'(s_k);
        acc_q = AW'(f_i) * AW'(s_k) + AW'(f_q) * AW'(c_k);
        y_i   = fit(acc_i);
        y_q   = fit(acc_q);
    end
endmodule

// File: rtl/trace_interp_mod.sv
`timescale 1ns/1ps
// Complex interpolating trace modulator (top).
// Stage A holds one compressed sample and steps through its UPS output
// slots; stage B registers the filtered value with its phase index, and
// the rotator drives the output from stage B.
// Assumes NTAP <= UPS and TRACE_IN >= 1. Traces are counted from reset.
module trace_interp_mod
    import tim_pkg::*;
#(
    parameter int DW       = 16,
    parameter int CW       = 16,
    parameter int UPS      = 8,
    parameter int NTAP     = 7,
    parameter int TRACE_IN = 385,
    parameter logic [NTAP*CW-1:0] COEFS = {16'sd2048, 16'sd8192, 16'sd20480, 16'sd32767,
                                           16'sd20480, 16'sd8192, 16'sd2048}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_valid,
    output logic                 s_ready,
    input  logic signed [DW-1:0] s_i,
    input  logic signed [DW-1:0] s_q,
    output logic                 m_valid,
    input  logic                 m_ready,
    output logic signed [DW-1:0] m_i,
    output logic signed [DW-1:0] m_q,
    output logic                 m_sot
);
    localparam int SW   = $clog2(UPS);
    localparam int CNTW = $clog2(TRACE_IN + 1);

    logic                 a_busy, a_first;
    logic [SW-1:0]        a_r;
    logic signed [DW-1:0] a_i, a_q;
    logic [CNTW-1:0]      in_cnt;
    phase_t               ph_next;

    logic                 b_valid, b_sot;
    phase_t               b_ph;
    logic signed [DW-1:0] b_fi, b_fq;

    logic                 a_adv, a_last, trace_head, take;
    phase_t               cur_ph;
    logic signed [DW-1:0] f_i, f_q;

    // handshake and slot bookkeeping
    always_comb begin
        a_adv      = a_busy && (!b_valid || m_ready);
        a_last     = (a_r == SW'(UPS - 1));
        trace_head = a_first && (a_r == '0);
        cur_ph     = trace_head ? 3'd1 : ph_next;
        s_ready    = !a_busy || (a_adv && a_last);
        take       = s_valid && s_ready;
    end

    // stage A: capture a compressed sample and walk its output slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_busy  <= 1'b0;
            a_first <= 1'b0;
            a_r     <= '0;
            a_i     <= '0;
            a_q     <= '0;
            in_cnt  <= '0;
        end else if (take) begin
            a_busy  <= 1'b1;
            a_r     <= '0;
            a_i     <= s_i;
            a_q     <= s_q;
            a_first <= (in_cnt == '0);
            in_cnt  <= (in_cnt == CNTW'(TRACE_IN - 1)) ? '0 : in_cnt + 1'b1;
        end else if (a_adv && a_last) begin
            a_busy  <= 1'b0;
        end else if (a_adv) begin
            a_r     <= a_r + 1'b1;
        end
    end

    // modulation phase: one eighth turn per output, restarted per trace
    always_ff @(posedge clk) begin
        if (!rst_n)     ph_next <= 3'd1;
        else if (a_adv) ph_next <= cur_ph + 3'd1;
    end

    tim_tap_slot #(
        .DW(DW), .CW(CW), .UPS(UPS), .NTAP(NTAP), .SW(SW), .COEFS(COEFS)
    ) u_slot (
        .x_i(a_i), .x_q(a_q), .slot(a_r), .f_i(f_i), .f_q(f_q)
    );

    // stage B: register filtered value, phase and trace marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_valid <= 1'b0;
            b_sot   <= 1'b0;
            b_ph    <= 3'd0;
            b_fi    <= '0;
            b_fq    <= '0;
        end else if (a_adv) begin
            b_valid <= 1'b1;
            b_sot   <= trace_head;
            b_ph    <= cur_ph;
            b_fi    <= f_i;
            b_fq    <= f_q;
        end else if (m_ready) begin
            b_valid <= 1'b0;
        end
    end

    tim_rotor #(.DW(DW)) u_rot (
        .f_i(b_fi), .f_q(b_fq), .ph(b_ph), .y_i(m_i), .y_q(m_q)
    );

    assign m_valid = b_valid;
    assign m_sot   = b_sot;

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_i) && $stable(m_q) && $stable(m_sot)));

    // R7
    backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready && a_busy) |-> !s_ready);

    // R5
    sot_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && b_sot) |-> (b_ph == 3'd1));

    // R4
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_adv && !trace_head) |=> (b_ph == $past(b_ph) + 3'd1));

    // R3
    gap_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_adv && int'(a_r) >= NTAP) |=> (b_fi == '0 && b_fq == '0));

    // R2
    trace_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(in_cnt) < TRACE_IN);
endmodule

// File: tb/sim_trace_interp_mod.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each comparing against a model
// built from the requirements.
module sim_trace_interp_mod;
    localparam int DW = 16, CW = 16, UPS = 6, NTAP = 5, TRACE_IN = 3;
    localparam int TRACE_OUT = TRACE_IN * UPS;
    localparam logic [NTAP*CW-1:0] BENCH_COEFS =
        {-16'sd9000, 16'sd12000, 16'sd32767, 16'sd20000, 16'sd16384};

    logic clk = 1'b0;
    logic rst_n, s_valid, s_ready, m_valid, m_ready, m_sot;
    logic signed [DW-1:0] s_i, s_q, m_i, m_q;

    int errors = 0, checks = 0;
    bit finished = 1'b0;
    int in_i[$], in_q[$], ex_i[$], ex_q[$], gt_i[$], gt_q[$];
    bit ex_s[$], gt_s[$];
    int stall_bad, gaps;

    always #2.5 clk = ~clk;

    trace_interp_mod #(
        .DW(DW), .CW(CW), .UPS(UPS), .NTAP(NTAP), .TRACE_IN(TRACE_IN), .COEFS(BENCH_COEFS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_i(s_i), .s_q(s_q),
        .m_valid(m_valid), .m_ready(m_ready), .m_i(m_i), .m_q(m_q), .m_sot(m_sot)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int coef(input int r);
        case (r)
            0: return 16384;
            1: return 20000;
            2: return 32767;
            3: return 12000;
            4: return -9000;
            default: return 0;
        endcase
    endfunction

    function automatic int sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int cosv(input int p);
        case (p)
            0: return 32768; 1: return 23170; 2: return 0; 3: return -23170;
            4: return -32768; 5: return -23170; 6: return 0; default: return 23170;
        endcase
    endfunction

    function automatic int sinv(input int p);
        return cosv((p + 6) % 8);
    endfunction

    // model from R3, R4, R5, R6
    task automatic build_expected();
        ex_i.delete(); ex_q.delete(); ex_s.delete();
        for (int t = 0; t < in_i.size() / TRACE_IN; t++)
            for (int j = 0; j < TRACE_IN; j++)
                for (int r = 0; r < UPS; r++) begin
                    int m, p, fi, fq;
                    m  = j * UPS + r;
                    fi = 0; fq = 0;
                    if (r < NTAP) begin
                        fi = sat16((longint'(coef(r)) * in_i[t*TRACE_IN+j] + 16384) >>> 15);
                        fq = sat16((longint'(coef(r)) * in_q[t*TRACE_IN+j] + 16384) >>> 15);
                    end
                    p = (m + 1) % 8;
                    ex_i.push_back(sat16((longint'(fi) * cosv(p) - longint'(fq) * sinv(p) + 16384) >>> 15));
                    ex_q.push_back(sat16((longint'(fi) * sinv(p) + longint'(fq) * cosv(p) + 16384) >>> 15));
                    ex_s.push_back(m == 0);
                end
    endtask

    task automatic drive_inputs();
        for (int k = 0; k < in_i.size(); k++) begin
            @(negedge clk);
            s_valid = 1'b1; s_i = DW'(in_i[k]); s_q = DW'(in_q[k]);
            #1;
            while (!s_ready) begin
                @(negedge clk); #1;
            end
        end
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    // mode 0: always ready, 1: alternate, 2: two low in five
    task automatic collect(input int mode, input int total);
        int n = 0, cyc = 0;
        bit started = 0, pend = 0;
        int hi = 0, hq = 0;
        bit hs = 0;
        while (n < total && cyc < total * 6 + 200) begin
            @(negedge clk); cyc++;
            case (mode)
                0: m_ready = 1'b1;
                1: m_ready = cyc[0];
                default: m_ready = (cyc % 5) >= 2;
            endcase
            #1;
            if (pend) begin
                if (!m_valid || int'(m_i) != hi || int'(m_q) != hq || m_sot != hs) stall_bad++;
                pend = 0;
            end
            if (mode == 0 && started && !m_valid) gaps++;
            if (m_valid) started = 1;
            if (m_valid && m_ready) begin
                gt_i.push_back(int'(m_i)); gt_q.push_back(int'(m_q)); gt_s.push_back(m_sot);
                n++;
            end else if (m_valid) begin
                hi = int'(m_i); hq = int'(m_q); hs = m_sot; pend = 1;
            end
        end
    endtask

    task automatic run_and_compare(input int mode, input string data_tag);
        int extra = 0;
        build_expected();
        gt_i.delete(); gt_q.delete(); gt_s.delete();
        stall_bad = 0; gaps = 0;
        fork
            drive_inputs();
            collect(mode, ex_i.size());
        join
        m_ready = 1'b1;
        repeat (10) begin
            @(negedge clk); #1;
            if (m_valid) extra++;
        end
        check(gt_i.size() == ex_i.size(), "R2", "output count", gt_i.size(), ex_i.size());
        check(extra == 0, "R2", "extra outputs", extra, 0);
        for (int k = 0; k < gt_i.size() && k < ex_i.size(); k++) begin
            int m, r, p;
            string tag;
            m = k % TRACE_OUT; r = m % UPS; p = (m + 1) % 8;
            tag = (r >= NTAP || p % 4 == 0) ? "R3" : data_tag;
            check(gt_i[k] == ex_i[k], tag, $sformatf("m_i[%0d]", k), gt_i[k], ex_i[k]);
            check(gt_q[k] == ex_q[k], tag, $sformatf("m_q[%0d]", k), gt_q[k], ex_q[k]);
            check(gt_s[k] == ex_s[k], "R2", $sformatf("m_sot[%0d]", k), gt_s[k], ex_s[k]);
        end
    endtask

    task automatic set_inputs(input int n, input int seed);
        in_i.delete(); in_q.delete();
        for (int k = 0; k < n; k++) begin
            in_i.push_back(((k * 7919 + seed) % 60001) - 30000);
            in_q.push_back(((k * 4273 + seed * 3) % 50001) - 25000);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b0; s_i = '0; s_q = '0;
        repeat (3) @(negedge clk);
        #1;
        check(m_valid == 1'b0, "R1", "m_valid in reset", m_valid, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(m_valid == 1'b0, "R1", "m_valid after reset", m_valid, 0);
        check(s_ready == 1'b1, "R1", "s_ready after reset", s_ready, 1);
    endtask

    task automatic t_basic();
        set_inputs(TRACE_IN, 11);
        run_and_compare(0, "R4");
        check(gaps == 0, "R9", "bubbles at full rate", gaps, 0);
    endtask

    task automatic t_two_traces();
        set_inputs(2 * TRACE_IN, 523);
        run_and_compare(0, "R5");
        check(gaps == 0, "R9", "bubbles across traces", gaps, 0);
        if (gt_i.size() > TRACE_OUT) begin
            check(gt_s[TRACE_OUT] == 1'b1, "R5", "second trace marker", gt_s[TRACE_OUT], 1);
            check(gt_i[TRACE_OUT] == ex_i[TRACE_OUT], "R5", "second trace phase restart",
                  gt_i[TRACE_OUT], ex_i[TRACE_OUT]);
        end
    endtask

    task automatic t_saturate();
        in_i.delete(); in_q.delete();
        in_i.push_back(32767);  in_q.push_back(-32768);
        in_i.push_back(1);      in_q.push_back(-1);
        in_i.push_back(-32768); in_q.push_back(32767);
        run_and_compare(0, "R6");
        if (gt_q.size() > 6) begin
            check(gt_q[2] == 32767, "R6", "rotation clamp", gt_q[2], 32767);
            check(gt_i[6] == 1, "R6", "tie rounds up", gt_i[6], 1);
        end
    endtask

    task automatic t_stall();
        set_inputs(2 * TRACE_IN, 97);
        run_and_compare(1, "R7");
        check(stall_bad == 0, "R8", "hold while stalled (alternate)", stall_bad, 0);
        set_inputs(2 * TRACE_IN, 2029);
        run_and_compare(2, "R7");
        check(stall_bad == 0, "R8", "hold while stalled (bursty)", stall_bad, 0);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0 expected 1 completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_two_traces();
        t_saturate();
        t_stall();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule